// File: doc/BRIEF.md
# Integer ALU with condition flags

This block is a purely combinational integer execution unit for a 64-bit datapath. It takes two prepared operands, a 4-bit opcode and a width select, and returns a result in the same evaluation. The width select chooses between 64-bit and 32-bit operation for each operation. The block covers several kinds of operation:

- arithmetic: add, subtract, add with carry and subtract with carry;
- logical: AND, bit-clear, OR, OR-NOT, XOR and XOR-NOT;
- address generation relative to the program counter.

A flag-setting request turns the arithmetic operations, AND and bit-clear into their flag-producing forms. These forms produce the next negative, zero, carry and overflow flags, together with a write-enable for the flag register. In every other case the incoming flags are passed through unchanged.

The second operand arrives already shifted or extended by an upstream stage. For address generation, operand A carries the program counter and operand B carries the immediate. Subtraction is performed as an addition of the inverted second operand with a carry-in of one. Because of this, the carry flag after a subtract means "no borrow".

Top module: `int_alu_nzcv`

## Requirements
- R1: Opcode encoding on `op_i`:
  - ADD=0, SUB=1, ADC=2, SBC=3
  - AND=4, BIC=5, ORR=6, ORN=7, EOR=8, EON=9
  - ADR=10, ADRP=11

  With `wide_i`=1 the arithmetic result is the 64-bit sum or difference. With `wide_i`=0 it is computed on the low 32 bits of each operand.
- R2: The flag vector is ordered `{N,Z,C,V}`, with N at bit 3 and V at bit 0. When flags are written, N equals result bit 63 (wide) or bit 31 (narrow). Z is 1 exactly when the result at the active width is all zeros.
- R3: For ADD, C is the carry out of the active-width sum and V is its signed overflow.
- R4: For SUB, C and V are the carry and overflow of op_a + ~op_b + 1 at the active width. C is therefore 1 when no borrow occurs.
- R5: ADC computes op_a + op_b + C and SBC computes op_a - op_b - (1 - C), where C is `nzcv_i[1]`. ADC takes its flags by the R3 rules and SBC by the R4 rules.
- R6: AND gives op_a & op_b and BIC gives op_a & ~op_b. Their flag-setting forms write C=0 and V=0, with N and Z taken from the result.
- R7: ORR, ORN, EOR and EON give op_a | op_b, op_a | ~op_b, op_a ^ op_b and op_a ^ ~op_b. They never write flags.
- R8: ADR gives op_a + op_b. ADRP gives (op_a with bits 11:0 cleared) + op_b. Both always work at 64 bits regardless of `wide_i` and never write flags.
- R9: With `wide_i`=0, bits 63:32 of the result are zero for every opcode other than ADR and ADRP.
- R10: `flag_we_o` is 1 only when `set_flags_i`=1 and the opcode is one of 0 to 5. Whenever it is 0, `nzcv_o` equals `nzcv_i`.
- R11: The result does not depend on `set_flags_i`.
- R12: Opcodes 12 to 15 give a zero result and never write flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (encoding in R1) |
| wide_i | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| set_flags_i | input | 1 | Request the flag-setting form |
| nzcv_i | input | 4 | Current flags {N,Z,C,V}; C feeds ADC/SBC |
| op_a_i | input | 64 | First operand, or PC for address ops |
| op_b_i | input | 64 | Prepared second operand, or immediate |
| result_o | output | 64 | Operation result |
| nzcv_o | output | 4 | Next flag values |
| flag_we_o | output | 1 | Flag register write-enable |

## Verification
The following properties are checked against every input combination the block sees:

- the flag pass-through whenever no write is enabled, and the gating of the write-enable by opcode and request;
- the N and Z flags against the result at the active width;
- the cleared carry and overflow after logical flag-setting operations;
- the zeroed upper half in narrow mode;
- the zero result of the unused opcodes.

Three things depend on exact arithmetic reference values and are shown only by the bench's scenarios: the carry and overflow values of additions and subtractions, the carry-in handling of ADC and SBC, and the page-aligned address sums. The same holds for the independence of the result from the flag request, which the bench shows by comparing paired vectors.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int XLEN     = 64;
    localparam int HLEN     = XLEN / 2;
    localparam int PAGE_LSB = 12;
    localparam int OP_W     = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_BIC  = 4'd5,
        OP_ORR  = 4'd6,
        OP_ORN  = 4'd7,
        OP_EOR  = 4'd8,
        OP_EON  = 4'd9,
        OP_ADR  = 4'd10,
        OP_ADRP = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_ARITH,
        GRP_LOGIC,
        GRP_ADDR,
        GRP_NONE
    } alu_grp_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic alu_grp_e op_group(logic [OP_W-1:0] op);
        alu_grp_e g;
        case (op)
            OP_ADD, OP_SUB, OP_ADC, OP_SBC:          g = GRP_ARITH;
            OP_AND, OP_BIC, OP_ORR, OP_ORN,
            OP_EOR, OP_EON:                          g = GRP_LOGIC;
            OP_ADR, OP_ADRP:                         g = GRP_ADDR;
            default:                                 g = GRP_NONE;
        endcase
        return g;
    endfunction

    function automatic logic op_has_flag_form(logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADC) ||
               (op == OP_SBC) || (op == OP_AND) || (op == OP_BIC);
    endfunction

    function automatic logic op_inverts_b(logic [OP_W-1:0] op);
        return (op == OP_SUB) || (op == OP_SBC);
    endfunction

endpackage

// File: rtl/alu_split_adder.sv
module alu_split_adder
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         wide_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int H = W / 2;

    logic [H:0] lo_sum;
    logic [H:0] hi_sum;
    logic       msb_a;
    logic       msb_b;
    logic       msb_s;

    always_comb begin
        lo_sum = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};
        hi_sum = {1'b0, a_i[W-1:H]} + {1'b0, b_i[W-1:H]} + {{H{1'b0}}, lo_sum[H]};
        sum_o  = {hi_sum[H-1:0], lo_sum[H-1:0]};
        msb_a  = wide_i ? a_i[W-1] : a_i[H-1];
        msb_b  = wide_i ? b_i[W-1] : b_i[H-1];
        msb_s  = wide_i ? hi_sum[H-1] : lo_sum[H-1];
        cout_o = wide_i ? hi_sum[H] : lo_sum[H];
        ovf_o  = (msb_a == msb_b) && (msb_s != msb_a);
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    res_o
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = ((op_i == OP_BIC) || (op_i == OP_ORN) || (op_i == OP_EON)) ? ~b_i : b_i;
        case (op_i)
            OP_AND, OP_BIC: res_o = a_i & b_eff;
            OP_ORR, OP_ORN: res_o = a_i | b_eff;
            OP_EOR, OP_EON: res_o = a_i ^ b_eff;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] res_i,
    input  logic         wide_i,
    input  alu_grp_e     grp_i,
    input  logic         cout_i,
    input  logic         ovf_i,
    input  logic         we_i,
    input  nzcv_t        flags_i,
    output nzcv_t        flags_o
);
    localparam int H = W / 2;

    nzcv_t fresh;

    always_comb begin
        fresh.n = wide_i ? res_i[W-1] : res_i[H-1];
        fresh.z = wide_i ? (res_i == '0) : (res_i[H-1:0] == '0);
        fresh.c = (grp_i == GRP_ARITH) ? cout_i : 1'b0;
        fresh.v = (grp_i == GRP_ARITH) ? ovf_i  : 1'b0;
        flags_o = we_i ? fresh : flags_i;
    end

endmodule

// File: rtl/int_alu_nzcv.sv
module int_alu_nzcv
    import int_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic            wide_i,
    input  logic            set_flags_i,
    input  logic [3:0]      nzcv_i,
    input  logic [XLEN-1:0] op_a_i,
    input  logic [XLEN-1:0] op_b_i,
    output logic [XLEN-1:0] result_o,
    output logic [3:0]      nzcv_o,
    output logic            flag_we_o
);
    alu_grp_e        grp;
    nzcv_t           flags_in;
    nzcv_t           flags_out;
    logic            eff_wide;
    logic [XLEN-1:0] add_a;
    logic [XLEN-1:0] add_b;
    logic            add_cin;
    logic [XLEN-1:0] add_sum;
    logic            add_cout;
    logic            add_ovf;
    logic [XLEN-1:0] logic_res;
    logic [XLEN-1:0] raw_res;
    logic [XLEN-1:0] res_masked;

    assign flags_in = nzcv_t'(nzcv_i);
    assign grp      = op_group(op_i);
    assign eff_wide = wide_i || (grp == GRP_ADDR);

    // Operand steering into the shared adder
    always_comb begin
        add_a   = op_a_i;
        add_b   = op_inverts_b(op_i) ? ~op_b_i : op_b_i;
        add_cin = 1'b0;
        case (op_i)
            OP_SUB:  add_cin = 1'b1;
            OP_ADC,
            OP_SBC:  add_cin = flags_in.c;
            OP_ADRP: add_a   = {op_a_i[XLEN-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
            default: add_cin = 1'b0;
        endcase
    end

    alu_split_adder #(.W(XLEN)) u_adder (
        .a_i    (add_a),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .wide_i (eff_wide),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    alu_logic_unit #(.W(XLEN)) u_logic (
        .op_i  (op_i),
        .a_i   (op_a_i),
        .b_i   (op_b_i),
        .res_o (logic_res)
    );

    always_comb begin
        case (grp)
            GRP_ARITH, GRP_ADDR: raw_res = add_sum;
            GRP_LOGIC:           raw_res = logic_res;
            default:             raw_res = '0;
        endcase
    end

    // Narrow-mode masking of the upper half, selected by generate
    genvar gi;
    generate
        for (gi = 0; gi < XLEN; gi++) begin : g_mask
            if (gi < HLEN) begin : g_low
                assign res_masked[gi] = raw_res[gi];
            end else begin : g_high
                assign res_masked[gi] = raw_res[gi] & eff_wide;
            end
        end
    endgenerate

    assign flag_we_o = set_flags_i && op_has_flag_form(op_i);

    alu_flag_gen #(.W(XLEN)) u_flags (
        .res_i   (res_masked),
        .wide_i  (eff_wide),
        .grp_i   (grp),
        .cout_i  (add_cout),
        .ovf_i   (add_ovf),
        .we_i    (flag_we_o),
        .flags_i (flags_in),
        .flags_o (flags_out)
    );

    assign result_o = res_masked;
    assign nzcv_o   = flags_out;

endmodule

// File: rtl/int_alu_nzcv_chk.sv
module int_alu_nzcv_chk
    import int_alu_pkg::*;
(
    input logic [OP_W-1:0] op_i,
    input logic            wide_i,
    input logic            set_flags_i,
    input logic [3:0]      nzcv_i,
    input logic [XLEN-1:0] result_o,
    input logic [3:0]      nzcv_o,
    input logic            flag_we_o
);
    logic known;
    logic is_addr;

    assign known   = !$isunknown({op_i, wide_i, set_flags_i, nzcv_i, result_o, nzcv_o, flag_we_o});
    assign is_addr = (op_i == OP_ADR) || (op_i == OP_ADRP);

    always_comb begin
        if (known) begin
            p_flag_echo_r10: assert (flag_we_o || (nzcv_o == nzcv_i))
                else $error("flags changed without write enable");
            p_we_gate_r10: assert (!flag_we_o || (set_flags_i && (op_i <= OP_BIC)))
                else $error("write enable on non-flag opcode");
            p_narrow_hi_zero_r9: assert (wide_i || is_addr || (result_o[XLEN-1:HLEN] == '0))
                else $error("upper half not zero in narrow mode");
            p_z_flag_r2: assert (!flag_we_o ||
                    (nzcv_o[2] == (wide_i ? (result_o == '0) : (result_o[HLEN-1:0] == '0))))
                else $error("Z flag mismatch");
            p_n_flag_r2: assert (!flag_we_o ||
                    (nzcv_o[3] == (wide_i ? result_o[XLEN-1] : result_o[HLEN-1])))
                else $error("N flag mismatch");
            p_logic_cv_clear_r6: assert (!(flag_we_o && ((op_i == OP_AND) || (op_i == OP_BIC))) ||
                    (nzcv_o[1:0] == 2'b00))
                else $error("logical op left C or V set");
            p_unused_op_r12: assert ((op_i < 4'd12) || ((result_o == '0) && !flag_we_o))
                else $error("unused opcode produced output");
        end
    end

endmodule

bind int_alu_nzcv int_alu_nzcv_chk u_chk (
    .op_i        (op_i),
    .wide_i      (wide_i),
    .set_flags_i (set_flags_i),
    .nzcv_i      (nzcv_i),
    .result_o    (result_o),
    .nzcv_o      (nzcv_o),
    .flag_we_o   (flag_we_o)
);

// File: tb/int_alu_nzcv_bench.sv
module int_alu_nzcv_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic [3:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic        set_flags_i = 1'b0;
    logic [3:0]  nzcv_i = '0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic [63:0] result_o;
    logic [3:0]  nzcv_o;
    logic        flag_we_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    int_alu_nzcv u_int_alu_nzcv (
        .op_i        (op_i),
        .wide_i      (wide_i),
        .set_flags_i (set_flags_i),
        .nzcv_i      (nzcv_i),
        .op_a_i      (op_a_i),
        .op_b_i      (op_b_i),
        .result_o    (result_o),
        .nzcv_o      (nzcv_o),
        .flag_we_o   (flag_we_o)
    );

    // Reference model: returns {we, nzcv[3:0], result[63:0]}
    function automatic logic [68:0] model(logic [3:0] op, logic wide, logic sf,
                                          logic [3:0] fin, logic [63:0] a, logic [63:0] b);
        logic [63:0] m;
        logic [63:0] bb;
        logic [64:0] s;
        logic [63:0] r;
        logic        ci, c, v, n, z, fop, sa, sb, sr;
        logic [3:0]  fo;
        m   = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        c   = 1'b0;
        v   = 1'b0;
        fop = 1'b0;
        r   = '0;
        if (op <= 4'd3) begin
            bb = ((op == 4'd1) || (op == 4'd3)) ? ~b : b;
            ci = (op == 4'd0) ? 1'b0 : (op == 4'd1) ? 1'b1 : fin[1];
            s  = {1'b0, a & m} + {1'b0, bb & m} + {64'd0, ci};
            r  = s[63:0] & m;
            c  = wide ? s[64] : s[32];
            sa = wide ? a[63] : a[31];
            sb = wide ? bb[63] : bb[31];
            sr = wide ? r[63] : r[31];
            v  = (sa == sb) && (sr != sa);
            fop = 1'b1;
        end else begin
            case (op)
                4'd4:  begin r = (a & b) & m;  fop = 1'b1; end
                4'd5:  begin r = (a & ~b) & m; fop = 1'b1; end
                4'd6:  r = (a | b) & m;
                4'd7:  r = (a | ~b) & m;
                4'd8:  r = (a ^ b) & m;
                4'd9:  r = (a ^ ~b) & m;
                4'd10: r = a + b;
                4'd11: r = {a[63:12], 12'h000} + b;
                default: r = '0;
            endcase
        end
        n  = (wide || op == 4'd10 || op == 4'd11) ? r[63] : r[31];
        z  = (r == 64'd0);
        fo = (sf && fop) ? {n, z, c, v} : fin;
        return {sf && fop, fo, r};
    endfunction

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2, 4'd3: return "R5";
            4'd4, 4'd5: return "R6";
            4'd6, 4'd7, 4'd8, 4'd9: return "R7";
            4'd10, 4'd11: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic wide, input logic sf,
                         input logic [3:0] fin, input logic [63:0] a, input logic [63:0] b,
                         input string tag);
        logic [68:0] exp;
        @(negedge clk);
        op_i = op; wide_i = wide; set_flags_i = sf; nzcv_i = fin;
        op_a_i = a; op_b_i = b;
        #1;
        exp = model(op, wide, sf, fin, a, b);
        n_checks++;
        if ({flag_we_o, nzcv_o, result_o} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d wide=%0b sf=%0b: actual we=%0b nzcv=%h res=%h expected we=%0b nzcv=%h res=%h",
                     tag, op, wide, sf, flag_we_o, nzcv_o, result_o, exp[68], exp[67:64], exp[63:0]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] r_off, r_on;
        void'($urandom(32'h1234_5678));

        // All-zero inputs: ADD of zeros, no flag request (R1, R10)
        apply(4'd0, 1'b1, 1'b0, 4'b0000, 64'd0, 64'd0, "R1");
        // R2: zero result sets Z; N from bit 31 in narrow mode
        apply(4'd0, 1'b1, 1'b1, 4'b0000, 64'd0, 64'd0, "R2");
        apply(4'd0, 1'b0, 1'b1, 4'b0000, 64'h0000_0000_7FFF_FFFF, 64'd1, "R2");
        // R3: unsigned carry out, 32 and 64 bit
        apply(4'd0, 1'b0, 1'b1, 4'b0000, 64'h0000_0000_FFFF_FFFF, 64'd1, "R3");
        apply(4'd0, 1'b1, 1'b1, 4'b0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R3");
        apply(4'd0, 1'b1, 1'b1, 4'b0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, "R3");
        // R4: equal operands -> Z=1, C=1 (no borrow); 0 - 1 -> C=0
        apply(4'd1, 1'b1, 1'b1, 4'b0000, 64'd5, 64'd5, "R4");
        apply(4'd1, 1'b0, 1'b1, 4'b0000, 64'd0, 64'd1, "R4");
        apply(4'd1, 1'b0, 1'b1, 4'b0000, 64'h0000_0000_8000_0000, 64'd1, "R4");
        // R5: carry-in both ways
        apply(4'd2, 1'b1, 1'b1, 4'b0010, 64'd10, 64'd20, "R5");
        apply(4'd2, 1'b0, 1'b1, 4'b0010, 64'h0000_0000_FFFF_FFFF, 64'd0, "R5");
        apply(4'd3, 1'b1, 1'b1, 4'b0000, 64'd10, 64'd3, "R5");
        apply(4'd3, 1'b1, 1'b1, 4'b0010, 64'd10, 64'd3, "R5");
        // R6: AND / BIC clear C and V even when inputs had them set
        apply(4'd4, 1'b1, 1'b1, 4'b0011, 64'hF000_0000_0000_00FF, 64'hF000_0000_0000_0F0F, "R6");
        apply(4'd5, 1'b0, 1'b1, 4'b1111, 64'h1234_5678_0000_FFFF, 64'h0000_0000_0000_FFFF, "R6");
        // R7: flag request ignored, flags echo
        apply(4'd8, 1'b1, 1'b1, 4'b1010, 64'hAAAA, 64'hAAAA, "R7");
        apply(4'd9, 1'b0, 1'b1, 4'b0101, 64'h1, 64'h0, "R7");
        apply(4'd7, 1'b1, 1'b1, 4'b0110, 64'h0, 64'h0, "R7");
        // R8: address ops are 64-bit even when narrow selected
        apply(4'd10, 1'b0, 1'b1, 4'b0000, 64'h0000_0001_0000_0FFF, 64'h0000_0000_0000_1001, "R8");
        apply(4'd11, 1'b0, 1'b1, 4'b1001, 64'h0000_0001_2345_6FFF, 64'h0000_0000_0000_2000, "R8");
        // R9: narrow logical op with high bits in operands
        apply(4'd6, 1'b0, 1'b0, 4'b0000, 64'hFFFF_FFFF_0000_0001, 64'hFFFF_0000_0000_0010, "R9");
        // R12: unused opcode
        apply(4'd13, 1'b1, 1'b1, 4'b1100, 64'hFFFF, 64'hFFFF, "R12");
        apply(4'd15, 1'b0, 1'b1, 4'b0011, 64'h1, 64'h2, "R12");

        // R11: same vector with and without flag request gives same result
        apply(4'd1, 1'b1, 1'b0, 4'b0000, 64'h8000_0000_0000_0000, 64'd1, "R11");
        r_off = result_o;
        apply(4'd1, 1'b1, 1'b1, 4'b0000, 64'h8000_0000_0000_0000, 64'd1, "R11");
        r_on = result_o;
        n_checks++;
        if (r_off !== r_on) begin
            n_fail++;
            $display("FAIL R11: actual %h expected %h", r_on, r_off);
        end

        // R10 / R1: random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  op;
            logic [63:0] a, b;
            op = 4'($urandom_range(0, 15));
            a  = {$urandom(), $urandom()};
            b  = {$urandom(), $urandom()};
            if ((i % 7) == 0) b = ~a;
            if ((i % 11) == 0) b = a;
            apply(op, 1'($urandom()), 1'($urandom()), 4'($urandom()), a, b, tag_of(op));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule